// File: doc/BRIEF.md
# Interrupt-on-Change Detector for an 8-Bit Input Port

This block watches an 8-bit input port and raises an interrupt when an enabled pin meets its trigger condition. Each pin has its own enable bit and its own comparison mode. In change mode the pin fires when its synchronized level differs from its level one cycle earlier. In compare mode it fires for as long as its level differs from a programmable reference bit. Raw pin levels first pass through a two-flop synchronizer. Only the synchronized value is compared, reported and captured.

The block has two states, `ST_IDLE` and `ST_PEND`.
- The ARM transition goes from `ST_IDLE` to `ST_PEND`. It is taken on the first cycle that any enabled pin triggers. On that edge the block records a one-hot flag for the lowest-numbered triggering pin and captures the whole synchronized port.
- The CLEAR transition goes from `ST_PEND` back to `ST_IDLE`. It is taken on the selected read strobe: a port read, or a capture read when the clear-select bit is set. CLEAR zeroes the flag. The capture register keeps its value until the next ARM.

While the block is in `ST_PEND`, every further pin activity is ignored. A compare-mode condition that is still active re-arms the block one cycle after CLEAR. The interrupt pin is either push-pull with a selectable active level, or open-drain. In open-drain mode the pin is driven low while pending and released otherwise.

Top module: `ioc_detector`

## Requirements
- R1: After reset the state is idle, `flag_o` and `cap_o` are 0, `port_o` is 0, and the interrupt pin is at its inactive level.
- R2: A pin whose `int_en` bit is 0 never sets its flag bit and never raises the interrupt.
- R3: With `cmp_mode[i]`=0, a change on `pin_in[i]` raises the interrupt and sets flag bit i on the third rising edge after the change. It is not yet raised after the second edge.
- R4: With `cmp_mode[i]`=1, pin i triggers while its synchronized level differs from `cmp_ref[i]`. A change of `cmp_ref` arms the block on the next edge. If the mismatch is still present after CLEAR, the block re-arms one edge later. Once the level matches, the block stays idle.
- R5: `flag_o` has at most one bit set, and bit i stands for pin i. When several pins trigger in the same cycle, the lowest-numbered pin is recorded.
- R6: On ARM, `cap_o` takes the synchronized port value of that cycle. It holds that value while pending and after CLEAR, until the next ARM.
- R7: While pending, further pin changes alter neither `flag_o` nor `cap_o`. A change-mode change that happened while pending raises no interrupt after CLEAR.
- R8: With `cfg_cap_clr`=0, `rd_port` clears the interrupt and `rd_cap` has no effect. With `cfg_cap_clr`=1, `rd_cap` clears it and `rd_port` has no effect. After the strobe edge the interrupt is inactive and `flag_o` is 0.
- R9: With `cfg_odr`=0, `irq_oe`=1 and `irq_out` equals pending when `cfg_pol`=1, or its inverse when `cfg_pol`=0. With `cfg_odr`=1, `irq_out`=0 and `irq_oe` equals pending, whatever `cfg_pol` is.
- R10: Clearing a pin's enable bit while its flag is set leaves the flag and the interrupt unchanged until CLEAR.
- R11: `port_o` shows `pin_in` after two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Raw pin levels |
| int_en | input | 8 | Per-pin interrupt enable |
| cmp_mode | input | 8 | Per-pin mode: 1 compare with reference, 0 change detect |
| cmp_ref | input | 8 | Per-pin reference level for compare mode |
| cfg_pol | input | 1 | Push-pull active level: 1 high, 0 low |
| cfg_odr | input | 1 | Open-drain output mode, overrides polarity |
| cfg_cap_clr | input | 1 | Clear source: 1 capture read, 0 port read |
| rd_port | input | 1 | Port read strobe |
| rd_cap | input | 1 | Capture read strobe |
| port_o | output | 8 | Synchronized port value |
| flag_o | output | 8 | One-hot flag of the pin that caused the interrupt |
| cap_o | output | 8 | Port value captured at the interrupt |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
Results fall due at fixed cycle counts after each stimulus:
- A pin change needs three rising edges to reach `flag_o`, `cap_o` and the interrupt pin: two synchronizer stages and the ARM edge.
- `port_o` needs two rising edges.
- A change of `cmp_ref` or `int_en` acts on the very next edge, because those inputs are not synchronized.
- A read strobe takes effect on the edge that samples it.

The bench drives every input on a falling edge and counts whole falling edges up to the due cycle before sampling. It also samples one edge early where the timing itself is under test, and there it expects the output to be unchanged.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } ioc_state_e;

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/ioc_trigger.sv
module ioc_trigger #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] last_level,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] mode,
    input  logic [WIDTH-1:0] ref_level,
    output logic [WIDTH-1:0] first_hit,
    output logic             any_hit
);
    logic [WIDTH-1:0] hit_vec;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            logic mismatch;
            // mode 1: compare with reference, mode 0: detect change
            assign mismatch   = mode[i] ? (level[i] ^ ref_level[i])
                                        : (level[i] ^ last_level[i]);
            assign hit_vec[i] = enable[i] & mismatch;
        end
    endgenerate

    // isolate lowest set bit: lowest-numbered pin wins
    assign first_hit = hit_vec & (~hit_vec + {{(WIDTH-1){1'b0}}, 1'b1});
    assign any_hit   = |hit_vec;

endmodule

// File: rtl/ioc_event_fsm.sv
module ioc_event_fsm
    import ioc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_hit,
    input  logic [WIDTH-1:0] first_hit,
    input  logic [WIDTH-1:0] level,
    input  logic             rd_port,
    input  logic             rd_cap,
    input  logic             cap_sel,
    output logic             pending,
    output logic [WIDTH-1:0] flag_q,
    output logic [WIDTH-1:0] cap_q
);
    ioc_state_e state_q, state_d;
    logic       clr_hit;

    assign clr_hit = cap_sel ? rd_cap : rd_port;

    // next-state logic: ARM and CLEAR transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_hit) state_d = ST_PEND;
            ST_PEND: if (clr_hit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            cap_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_hit) begin
                        flag_q <= first_hit;
                        cap_q  <= level;
                    end
                end
                ST_PEND: begin
                    if (clr_hit) flag_q <= '0;
                end
                default: flag_q <= '0;
            endcase
        end
    end

    assign pending = (state_q == ST_PEND);

    // R5: never more than one flag bit
    a_r5_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_q));

    // R7: registers frozen while pending and not cleared
    a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr_hit) |=> ($stable(flag_q) && $stable(cap_q) && pending));

    // R8: selected strobe returns to idle with an empty flag
    a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && clr_hit) |=> (!pending && (flag_q == '0)));

    // R6: capture holds the port value seen on the ARM cycle
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && any_hit) |=> (cap_q == $past(level)));

endmodule

// File: rtl/ioc_pin_drive.sv
module ioc_pin_drive (
    input  logic pending,
    input  logic pol_high,
    input  logic open_drain,
    output logic pin_level,
    output logic pin_drive
);
    always_comb begin
        if (open_drain) begin
            pin_level = 1'b0;
            pin_drive = pending;
        end else begin
            pin_level = pol_high ? pending : ~pending;
            pin_drive = 1'b1;
        end
    end

endmodule

// File: rtl/ioc_detector.sv
module ioc_detector #(
    parameter int WIDTH     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] int_en,
    input  logic [WIDTH-1:0] cmp_mode,
    input  logic [WIDTH-1:0] cmp_ref,
    input  logic             cfg_pol,
    input  logic             cfg_odr,
    input  logic             cfg_cap_clr,
    input  logic             rd_port,
    input  logic             rd_cap,
    output logic [WIDTH-1:0] port_o,
    output logic [WIDTH-1:0] flag_o,
    output logic [WIDTH-1:0] cap_o,
    output logic             irq_out,
    output logic             irq_oe
);
    logic [WIDTH-1:0] level_s;
    logic [WIDTH-1:0] last_q;
    logic [WIDTH-1:0] first_hit;
    logic             any_hit;
    logic             pending;

    ioc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .q_out (level_s)
    );

    // previous-value reference, refreshed every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= level_s;
    end

    ioc_trigger #(.WIDTH(WIDTH)) u_trig (
        .level      (level_s),
        .last_level (last_q),
        .enable     (int_en),
        .mode       (cmp_mode),
        .ref_level  (cmp_ref),
        .first_hit  (first_hit),
        .any_hit    (any_hit)
    );

    ioc_event_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_hit   (any_hit),
        .first_hit (first_hit),
        .level     (level_s),
        .rd_port   (rd_port),
        .rd_cap    (rd_cap),
        .cap_sel   (cfg_cap_clr),
        .pending   (pending),
        .flag_q    (flag_o),
        .cap_q     (cap_o)
    );

    ioc_pin_drive u_drive (
        .pending    (pending),
        .pol_high   (cfg_pol),
        .open_drain (cfg_odr),
        .pin_level  (irq_out),
        .pin_drive  (irq_oe)
    );

    assign port_o = level_s;

    // R2: a freshly raised flag names only a pin enabled on the ARM cycle
    a_r2_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ((flag_o & ~$past(int_en)) == '0));

    // R9: open-drain never drives high
    a_r9_odr_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_odr |-> !(irq_oe && irq_out));

    // R1/R9: an active pin always comes with a set flag
    a_r9_active_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_odr && (irq_out == cfg_pol)) |-> $onehot(flag_o));

endmodule

// File: tb/ioc_detector_bench.sv
module ioc_detector_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0, int_en = '0, cmp_mode = '0, cmp_ref = '0;
    logic       cfg_pol = 1'b0, cfg_odr = 1'b0, cfg_cap_clr = 1'b0;
    logic       rd_port = 1'b0, rd_cap = 1'b0;
    logic [7:0] port_o, flag_o, cap_o;
    logic       irq_out, irq_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ioc_detector u_ioc_detector (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .int_en(int_en),
        .cmp_mode(cmp_mode), .cmp_ref(cmp_ref), .cfg_pol(cfg_pol),
        .cfg_odr(cfg_odr), .cfg_cap_clr(cfg_cap_clr), .rd_port(rd_port),
        .rd_cap(rd_cap), .port_o(port_o), .flag_o(flag_o), .cap_o(cap_o),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected {irq_out, irq_oe} for a pending value
    function automatic logic [1:0] exp_drv(input bit p);
        if (cfg_odr) return {1'b0, p};
        return {(cfg_pol ? p : ~p), 1'b1};
    endfunction

    task automatic chk_irq(input bit p, input string req);
        chk({irq_out, irq_oe} == exp_drv(p), req, {irq_out, irq_oe}, exp_drv(p));
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pulse a read strobe for one edge; port_rd=1 selects rd_port
    task automatic pulse_rd(input bit port_rd);
        if (port_rd) rd_port = 1'b1; else rd_cap = 1'b1;
        @(negedge clk);
        rd_port = 1'b0;
        rd_cap  = 1'b0;
    endtask

    task automatic go_idle();
        int_en = '0;
        wait_n(4);
        rd_port = 1'b1;
        rd_cap  = 1'b1;
        @(negedge clk);
        rd_port = 1'b0;
        rd_cap  = 1'b0;
        wait_n(1);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk(flag_o == 8'h00, "R1 flag", flag_o, 8'h00);
        chk(cap_o == 8'h00, "R1 cap", cap_o, 8'h00);
        chk(port_o == 8'h00, "R1 port", port_o, 8'h00);
        chk_irq(1'b0, "R1 irq");

        // R3 R5 R6: exhaustive masks in change mode
        int_en = 8'hFF;
        cmp_mode = 8'h00;
        wait_n(1);
        for (int m = 1; m < 256; m++) begin
            logic [7:0] mk;
            logic [7:0] low;
            mk  = m[7:0];
            low = mk & (~mk + 8'd1);
            pin_in = mk;
            wait_n(2);
            chk_irq(1'b0, "R3 not before third edge");
            wait_n(1);
            chk(flag_o == low, "R5 lowest flag rise", flag_o, low);
            chk(cap_o == mk, "R6 capture rise", cap_o, mk);
            chk_irq(1'b1, "R3 irq raised");
            pulse_rd(1'b1);
            chk_irq(1'b0, "R8 port clear");
            chk(cap_o == mk, "R6 capture kept after clear", cap_o, mk);
            pin_in = 8'h00;
            wait_n(3);
            chk(flag_o == low, "R5 lowest flag fall", flag_o, low);
            chk(cap_o == 8'h00, "R6 capture fall", cap_o, 8'h00);
            pulse_rd(1'b1);
            chk(flag_o == 8'h00, "R8 flag cleared", flag_o, 8'h00);
        end

        // R2 disabled pins
        for (int i = 0; i < 8; i++) begin
            go_idle();
            int_en = ~(8'h01 << i);
            pin_in = 8'h01 << i;
            wait_n(5);
            chk(flag_o == 8'h00, "R2 disabled flag", flag_o, 8'h00);
            chk_irq(1'b0, "R2 disabled irq");
            pin_in = 8'h00;
            wait_n(5);
            chk_irq(1'b0, "R2 disabled irq fall");
        end
        go_idle();
        int_en = 8'hFE;
        pin_in = 8'h09;
        wait_n(3);
        chk(flag_o == 8'h08, "R2 disabled lower pin skipped", flag_o, 8'h08);
        pin_in = 8'h00;
        go_idle();

        // R4 compare mode and re-arm
        cmp_mode = 8'hFF;
        cmp_ref  = 8'h00;
        int_en   = 8'hFF;
        wait_n(2);
        chk_irq(1'b0, "R4 match idle");
        cmp_ref = 8'h10;
        wait_n(1);
        chk(flag_o == 8'h10, "R4 ref mismatch flag", flag_o, 8'h10);
        chk(cap_o == 8'h00, "R4 capture", cap_o, 8'h00);
        pulse_rd(1'b1);
        chk_irq(1'b0, "R4 idle after clear");
        wait_n(1);
        chk_irq(1'b1, "R4 re-arm");
        chk(flag_o == 8'h10, "R4 re-arm flag", flag_o, 8'h10);
        pin_in = 8'h10;
        wait_n(3);
        pulse_rd(1'b1);
        wait_n(2);
        chk_irq(1'b0, "R4 matched stays idle");
        chk(flag_o == 8'h00, "R4 matched flag", flag_o, 8'h00);
        go_idle();
        pin_in = 8'h00;
        cmp_ref = 8'h00;
        cmp_mode = 8'h00;
        wait_n(3);

        // R7 activity ignored while pending
        int_en = 8'hFF;
        wait_n(1);
        pin_in = 8'h04;
        wait_n(3);
        chk(flag_o == 8'h04, "R7 first event", flag_o, 8'h04);
        pin_in = 8'h26;
        wait_n(4);
        chk(flag_o == 8'h04, "R7 flag frozen", flag_o, 8'h04);
        chk(cap_o == 8'h04, "R7 capture frozen", cap_o, 8'h04);
        pulse_rd(1'b1);
        wait_n(4);
        chk_irq(1'b0, "R7 no late event");
        chk(flag_o == 8'h00, "R7 no late flag", flag_o, 8'h00);

        // R8 clear source select
        for (int sel = 0; sel < 2; sel++) begin
            cfg_cap_clr = sel[0];
            pin_in = ~pin_in;
            wait_n(3);
            chk_irq(1'b1, "R8 pending");
            pulse_rd(sel == 0 ? 1'b0 : 1'b1);
            wait_n(1);
            chk_irq(1'b1, "R8 wrong strobe ignored");
            chk(flag_o != 8'h00, "R8 flag kept", flag_o, 8'h01);
            pulse_rd(sel == 0 ? 1'b1 : 1'b0);
            chk_irq(1'b0, "R8 selected strobe clears");
            chk(flag_o == 8'h00, "R8 flag zero", flag_o, 8'h00);
        end
        cfg_cap_clr = 1'b0;

        // R9 output drive modes
        for (int c = 0; c < 4; c++) begin
            cfg_pol = c[0];
            cfg_odr = c[1];
            wait_n(1);
            chk_irq(1'b0, "R9 inactive level");
            pin_in = pin_in ^ 8'h80;
            wait_n(3);
            chk_irq(1'b1, "R9 active level");
            pulse_rd(1'b1);
            chk_irq(1'b0, "R9 back inactive");
        end
        cfg_pol = 1'b0;
        cfg_odr = 1'b0;

        // R10 enable removed while flagged
        pin_in = pin_in ^ 8'h08;
        wait_n(3);
        chk(flag_o == 8'h08, "R10 flagged", flag_o, 8'h08);
        int_en = 8'h00;
        wait_n(2);
        chk(flag_o == 8'h08, "R10 flag kept", flag_o, 8'h08);
        chk_irq(1'b1, "R10 irq kept");
        pulse_rd(1'b1);
        chk(flag_o == 8'h00, "R10 cleared", flag_o, 8'h00);

        // R11 synchronizer latency
        pin_in = 8'hA5;
        wait_n(1);
        chk(port_o != 8'hA5, "R11 not after one edge", port_o, 8'h00);
        wait_n(1);
        chk(port_o == 8'hA5, "R11 port value", port_o, 8'hA5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule